// File: doc/BRIEF.md
# Autovectoring Shared Interrupt Controller

This block gathers a set of single-cycle interrupt request pulses onto one shared processor interrupt line. Every source sits in a fixed priority slot. Each slot has a sticky request flag and an enable bit. The block continuously works out the highest-priority slot that is both flagged and enabled. It turns that slot into a vector byte equal to four times the slot index, so the vectors step by four from 0x00. Some slots are reserved holes. Their flags and enables are tied low, so they can never win.

The block also sits between the CPU's code-fetch port and program memory. When the autovector enable bit of the setup register is set, a fetch of the fixed code address 0x0045 returns the vector byte instead of the memory byte. The preceding byte at 0x0044 still comes from memory. A long-jump instruction placed there therefore uses a page byte taken from memory and a low byte supplied by the controller, and lands on the matching entry of a 256-byte jump table. The slot count and the reserved-slot mask are parameters. Another copy of the block, with 14 slots, serves a second interrupt line.

The fetch path is a small state machine:
- **FS_IDLE**: no fetch is in flight.
- **FS_PASS**: the data phase of an ordinary fetch.
- **FS_SUBST**: the data phase of a substituted fetch.

The next state depends only on the fetch request, whatever the current state is:
- From any state, a fetch of 0x0045 with autovectoring on moves to FS_SUBST.
- From any state, any other fetch moves to FS_PASS.
- From any state, a cycle without a fetch returns to FS_IDLE.

Top module: `av_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[k]` for a non-reserved slot k sets flag k at the next clock edge. The flag stays set until software clears it.
- R2: Writing to the flag register (`reg_addr` = 1) clears every flag whose data bit is 1. Data bits of 0 leave their flags alone. If a pulse and a clear hit the same flag in the same cycle, the flag ends up set.
- R3: `irq_out` is high exactly when at least one slot is both flagged and enabled. A flagged slot whose enable is clear never raises `irq_out`.
- R4: `vec_out` is 4 × (lowest index among the slots that are flagged and enabled), so index 0 is the highest priority. `vec_out` is 0x00 when no slot is both flagged and enabled.
- R5: The reserved slots are 7, 17, 25 and 26, which give vectors 0x1C, 0x44, 0x64 and 0x68. Their flag bits and enable bits always read 0, and they never affect `irq_out` or `vec_out`.
- R6: With setup bit 0 (autovector enable) set, a fetch of address 0x0045 returns the vector byte on `fetch_rdata` in the cycle after the address is presented (the data phase).
- R7: When autovectoring is off, or for any address other than 0x0045 (including 0x0044), the data-phase `fetch_rdata` equals `mem_rdata`.
- R8: The substituted byte is the vector held at the clock edge that accepts the fetch address. A request flagged at that same edge changes `vec_out` but not the substituted byte.
- R9: The register map is read combinationally through `reg_rdata`. Address 0 is the enable register (one bit per slot, read/write). Address 1 is the flag register (read, write-1-to-clear). Address 2 is the setup register, with bit 0 as the autovector enable.
- R10: After reset all flags, all enables and the autovector enable are 0, so `irq_out` is 0 and `vec_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | NUM_SLOTS | One-cycle request pulse per slot |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 flag, 2 setup |
| reg_wdata | input | NUM_SLOTS | Register write data |
| reg_rdata | output | NUM_SLOTS | Register read data for `reg_addr` |
| fetch_en | input | 1 | Code fetch address valid |
| fetch_addr | input | ADDR_W | Code fetch address |
| mem_rdata | input | 8 | Program memory byte, valid in the data phase |
| fetch_rdata | output | 8 | Byte returned to the CPU in the data phase |
| irq_out | output | 1 | Shared interrupt request |
| vec_out | output | 8 | Current vector byte |

## Verification
The priority encoder is driven with several flags pending at once: slots 9, 12, 20 and 30. Those flags are then cleared one by one, from the highest priority down. This separates a lowest-index-wins encoder from one that prefers higher indices, and it confirms that a cleared flag hands the vector to the next pending slot. Masked patterns flag slots whose enables are clear, which tells a line that looks at enables apart from one that looks only at flags. A pattern made only of reserved slots shows that the holes cannot become pending. Fetches of 0x0044, of 0x0045 with autovectoring on and off, and of 0x0045 together with a higher-priority request arriving at the same edge separate address decoding, the enable gating and the capture timing of the substituted byte.

// File: rtl/av_irq_pkg.sv
package av_irq_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] RA_ENABLE = 2'd0;
    localparam logic [REG_AW-1:0] RA_FLAG   = 2'd1;
    localparam logic [REG_AW-1:0] RA_SETUP  = 2'd2;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_PASS  = 2'd1,
        FS_SUBST = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/av_irq_regs.sv
module av_irq_regs
    import av_irq_pkg::*;
#(
    parameter int                   NUM_SLOTS = 31,
    parameter logic [NUM_SLOTS-1:0] RSVD_MASK = 31'h0602_0080
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] src_pulse,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [NUM_SLOTS-1:0] reg_wdata,
    output logic [NUM_SLOTS-1:0] reg_rdata,
    output logic [NUM_SLOTS-1:0] flag_q,
    output logic [NUM_SLOTS-1:0] en_q,
    output logic                 av_en_q
);

    logic                 wr_en_reg;
    logic                 wr_flag_reg;
    logic                 wr_setup_reg;
    logic [NUM_SLOTS-1:0] clr_mask;

    assign wr_en_reg    = reg_wr && (reg_addr == RA_ENABLE);
    assign wr_flag_reg  = reg_wr && (reg_addr == RA_FLAG);
    assign wr_setup_reg = reg_wr && (reg_addr == RA_SETUP);
    assign clr_mask     = wr_flag_reg ? reg_wdata : '0;

    // per-slot storage; reserved slots hold no state at all
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (RSVD_MASK[g]) begin : g_hole
            assign flag_q[g] = 1'b0;
            assign en_q[g]   = 1'b0;
        end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q[g] <= 1'b0;
                    en_q[g]   <= 1'b0;
                end else begin
                    // a new pulse outranks a simultaneous clear
                    flag_q[g] <= (flag_q[g] & ~clr_mask[g]) | src_pulse[g];
                    if (wr_en_reg) begin
                        en_q[g] <= reg_wdata[g];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            av_en_q <= 1'b0;
        end else if (wr_setup_reg) begin
            av_en_q <= reg_wdata[0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_ENABLE: reg_rdata = en_q;
            RA_FLAG:   reg_rdata = flag_q;
            RA_SETUP:  reg_rdata = {{(NUM_SLOTS-1){1'b0}}, av_en_q};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/av_irq_prio.sv
module av_irq_prio #(
    parameter int NUM_SLOTS   = 31,
    parameter int VEC_W       = 8,
    parameter int STRIDE_LOG2 = 2
) (
    input  logic [NUM_SLOTS-1:0] active,
    output logic                 any_o,
    output logic [VEC_W-1:0]     vec_o
);

    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [IDX_W-1:0] win_idx;

    // scan from the lowest priority upward so the lowest index is kept
    always_comb begin
        any_o   = 1'b0;
        win_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (active[i]) begin
                any_o   = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    assign vec_o = any_o ? (VEC_W'(win_idx) << STRIDE_LOG2) : '0;

endmodule

// File: rtl/av_irq_splice.sv
module av_irq_splice
    import av_irq_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              VEC_W    = 8,
    parameter logic [ADDR_W-1:0] LOW_ADDR = 16'h0045
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              av_en,
    input  logic [VEC_W-1:0]  vec_cur,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        fetch_rdata
);

    fetch_state_e     state_q;
    fetch_state_e     state_d;
    logic [VEC_W-1:0] vec_hold_q;
    logic             hit;

    assign hit = fetch_en && av_en && (fetch_addr == LOW_ADDR);

    // state register and vector snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= FS_IDLE;
            vec_hold_q <= '0;
        end else begin
            state_q <= state_d;
            if (hit) begin
                vec_hold_q <= vec_cur;
            end
        end
    end

    // next state
    always_comb begin
        state_d = FS_IDLE;
        unique case (state_q)
            FS_IDLE, FS_PASS, FS_SUBST: begin
                if (hit) begin
                    state_d = FS_SUBST;
                end else if (fetch_en) begin
                    state_d = FS_PASS;
                end else begin
                    state_d = FS_IDLE;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FS_SUBST: fetch_rdata = 8'(vec_hold_q);
            default:  fetch_rdata = mem_rdata;
        endcase
    end

endmodule

// File: rtl/av_irq_ctrl.sv
module av_irq_ctrl
    import av_irq_pkg::*;
#(
    parameter int                   NUM_SLOTS = 31,
    parameter logic [NUM_SLOTS-1:0] RSVD_MASK = 31'h0602_0080,
    parameter int                   ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    LOW_ADDR  = 16'h0045
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] src_pulse,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [NUM_SLOTS-1:0] reg_wdata,
    output logic [NUM_SLOTS-1:0] reg_rdata,
    input  logic                 fetch_en,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic [7:0]           mem_rdata,
    output logic [7:0]           fetch_rdata,
    output logic                 irq_out,
    output logic [7:0]           vec_out
);

    localparam int VEC_W       = 8;
    localparam int STRIDE_LOG2 = 2;

    logic [NUM_SLOTS-1:0] flag_q;
    logic [NUM_SLOTS-1:0] en_q;
    logic                 av_en_q;
    logic [NUM_SLOTS-1:0] active;

    av_irq_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .RSVD_MASK (RSVD_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flag_q    (flag_q),
        .en_q      (en_q),
        .av_en_q   (av_en_q)
    );

    assign active = flag_q & en_q;

    av_irq_prio #(
        .NUM_SLOTS   (NUM_SLOTS),
        .VEC_W       (VEC_W),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_prio (
        .active (active),
        .any_o  (irq_out),
        .vec_o  (vec_out)
    );

    av_irq_splice #(
        .ADDR_W   (ADDR_W),
        .VEC_W    (VEC_W),
        .LOW_ADDR (LOW_ADDR)
    ) u_splice (
        .clk         (clk),
        .rst_n       (rst_n),
        .av_en       (av_en_q),
        .vec_cur     (vec_out),
        .fetch_en    (fetch_en),
        .fetch_addr  (fetch_addr),
        .mem_rdata   (mem_rdata),
        .fetch_rdata (fetch_rdata)
    );

endmodule

// File: rtl/av_irq_ctrl_chk.sv
module av_irq_ctrl_chk #(
    parameter int                   NUM_SLOTS = 31,
    parameter logic [NUM_SLOTS-1:0] RSVD_MASK = 31'h0602_0080,
    parameter int                   ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    LOW_ADDR  = 16'h0045
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] src_pulse,
    input logic                 reg_wr,
    input logic [1:0]           reg_addr,
    input logic [NUM_SLOTS-1:0] reg_wdata,
    input logic                 fetch_en,
    input logic [ADDR_W-1:0]    fetch_addr,
    input logic [7:0]           mem_rdata,
    input logic [7:0]           fetch_rdata,
    input logic                 irq_out,
    input logic [7:0]           vec_out,
    input logic [NUM_SLOTS-1:0] flags,
    input logic [NUM_SLOTS-1:0] enables,
    input logic                 av_en
);

    // R1
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse != '0) |=>
            ((flags & $past(src_pulse & ~RSVD_MASK)) == $past(src_pulse & ~RSVD_MASK)));

    // R2
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=>
            ((flags & $past(reg_wdata & ~src_pulse)) == '0));

    // R4
    vec_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |->
            ((((flags & enables) >> vec_out[7:2]) & NUM_SLOTS'(1)) != '0) &&
            (((flags & enables) & ~({NUM_SLOTS{1'b1}} << vec_out[7:2])) == '0));

    // R4
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> (vec_out == 8'h00));

    // R5
    holes_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags | enables) & RSVD_MASK) == '0);

    // R6
    subst_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && av_en && fetch_addr == LOW_ADDR) |=>
            (fetch_rdata == $past(vec_out)));

    // R7
    pass_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !(av_en && fetch_addr == LOW_ADDR)) |=>
            (fetch_rdata == mem_rdata));

endmodule

bind av_irq_ctrl av_irq_ctrl_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .RSVD_MASK (RSVD_MASK),
    .ADDR_W    (ADDR_W),
    .LOW_ADDR  (LOW_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_pulse   (src_pulse),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .fetch_en    (fetch_en),
    .fetch_addr  (fetch_addr),
    .mem_rdata   (mem_rdata),
    .fetch_rdata (fetch_rdata),
    .irq_out     (irq_out),
    .vec_out     (vec_out),
    .flags       (flag_q),
    .enables     (en_q),
    .av_en       (av_en_q)
);

// File: tb/sim_av_irq_ctrl.sv
`timescale 1ns/1ps
module sim_av_irq_ctrl;

    localparam int          N    = 31;
    localparam logic [N-1:0] RSVD = 31'h0602_0080;
    localparam logic [N-1:0] ALL  = {N{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_pulse = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          fetch_en = 1'b0;
    logic [15:0]   fetch_addr = '0;
    logic [7:0]    mem_rdata = '0;
    logic [7:0]    fetch_rdata;
    logic          irq_out;
    logic [7:0]    vec_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    av_irq_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_pulse   (src_pulse),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fetch_en    (fetch_en),
        .fetch_addr  (fetch_addr),
        .mem_rdata   (mem_rdata),
        .fetch_rdata (fetch_rdata),
        .irq_out     (irq_out),
        .vec_out     (vec_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); src_pulse = m;
        @(negedge clk); src_pulse = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic fetch(input logic [15:0] a, input logic [7:0] memb, output logic [7:0] got);
        @(negedge clk); fetch_en = 1'b1; fetch_addr = a;
        @(negedge clk); fetch_en = 1'b0; mem_rdata = memb;
        #0.5;
        got = fetch_rdata;
    endtask

    task automatic wipe();
        wr(2'd1, ALL);
        wr(2'd0, '0);
        wr(2'd2, '0);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        rd(2'd1, d); chk("R10", "flags after reset", 32'(d), 0);
        rd(2'd0, d); chk("R10", "enables after reset", 32'(d), 0);
        rd(2'd2, d); chk("R10", "setup after reset", 32'(d), 0);
        chk("R10", "irq after reset", 32'(irq_out), 0);
        chk("R4", "vector with nothing pending", 32'(vec_out), 0);
    endtask

    task automatic t_sticky_and_enable();
        logic [N-1:0] d;
        pulse(N'(1) << 9);
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R1", "flag 9 sticky", 32'(d), 32'(N'(1) << 9));
        chk("R3", "irq low while disabled", 32'(irq_out), 0);
        wr(2'd0, ALL);
        rd(2'd0, d); chk("R9", "enable readback", 32'(d), 32'h79FD_FF7F);
        chk("R5", "reserved enables read zero", 32'(d & RSVD), 0);
        chk("R3", "irq after enable", 32'(irq_out), 1);
        chk("R4", "vector for slot 9", 32'(vec_out), 32'h24);
    endtask

    task automatic t_priority_walk();
        pulse((N'(1) << 12) | (N'(1) << 20) | (N'(1) << 30));
        chk("R4", "slot 9 wins over 12/20/30", 32'(vec_out), 32'h24);
        wr(2'd1, N'(1) << 9);
        chk("R2", "after clearing 9", 32'(vec_out), 32'h30);
        wr(2'd1, N'(1) << 12);
        chk("R2", "after clearing 12", 32'(vec_out), 32'h50);
        wr(2'd1, N'(1) << 20);
        chk("R2", "after clearing 20", 32'(vec_out), 32'h78);
        wr(2'd1, N'(1) << 30);
        chk("R3", "irq after last clear", 32'(irq_out), 0);
        chk("R4", "vector after last clear", 32'(vec_out), 0);
    endtask

    task automatic t_write_zero_and_set_wins();
        logic [N-1:0] d;
        pulse(N'(1) << 3);
        wr(2'd1, '0);
        rd(2'd1, d); chk("R2", "zero write keeps flag 3", 32'(d), 32'h8);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = N'(1) << 4; src_pulse = N'(1) << 4;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; src_pulse = '0;
        rd(2'd1, d); chk("R2", "pulse beats clear on slot 4", 32'(d), 32'h18);
        chk("R4", "vector slot 3", 32'(vec_out), 32'h0C);
        wipe();
    endtask

    task automatic t_mask();
        logic [N-1:0] d;
        pulse((N'(1) << 3) | (N'(1) << 5));
        wr(2'd0, N'(1) << 5);
        chk("R3", "only slot 5 enabled, irq", 32'(irq_out), 1);
        chk("R4", "masked slot 3 skipped", 32'(vec_out), 32'h14);
        wr(2'd0, '0);
        chk("R3", "all masked, irq", 32'(irq_out), 0);
        chk("R4", "all masked, vector", 32'(vec_out), 0);
        rd(2'd1, d); chk("R1", "masked flags persist", 32'(d), 32'h28);
        wipe();
    endtask

    task automatic t_reserved();
        logic [N-1:0] d;
        wr(2'd0, ALL);
        pulse(RSVD);
        rd(2'd1, d); chk("R5", "reserved flags stay zero", 32'(d), 0);
        chk("R5", "reserved slots leave irq low", 32'(irq_out), 0);
        wipe();
    endtask

    task automatic t_fetch();
        logic [7:0] got;
        wr(2'd0, ALL);
        pulse(N'(1) << 5);
        fetch(16'h0045, 8'hA5, got);
        chk("R7", "0x45 with autovector off", 32'(got), 32'hA5);
        wr(2'd2, N'(1));
        fetch(16'h0044, 8'h12, got);
        chk("R7", "page byte 0x44 from memory", 32'(got), 32'h12);
        fetch(16'h0045, 8'hA5, got);
        chk("R6", "0x45 substituted", 32'(got), 32'h14);
        fetch(16'h0046, 8'h3C, got);
        chk("R7", "0x46 from memory", 32'(got), 32'h3C);
        // back-to-back page then low byte
        @(negedge clk); fetch_en = 1'b1; fetch_addr = 16'h0044;
        @(negedge clk); fetch_addr = 16'h0045; mem_rdata = 8'h02;
        #0.5; chk("R7", "back-to-back page byte", 32'(fetch_rdata), 32'h02);
        @(negedge clk); fetch_en = 1'b0; mem_rdata = 8'hEE;
        #0.5; chk("R6", "back-to-back low byte", 32'(fetch_rdata), 32'h14);
    endtask

    task automatic t_capture();
        @(negedge clk);
        fetch_en = 1'b1; fetch_addr = 16'h0045; src_pulse = N'(1) << 1;
        @(negedge clk);
        fetch_en = 1'b0; src_pulse = '0; mem_rdata = 8'h99;
        #0.5;
        chk("R8", "substituted byte keeps old vector", 32'(fetch_rdata), 32'h14);
        chk("R8", "live vector moved to slot 1", 32'(vec_out), 32'h04);
        wipe();
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky_and_enable();
        t_priority_walk();
        t_write_zero_and_set_wins();
        t_mask();
        t_reserved();
        t_fetch();
        t_capture();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule